// File: doc/BRIEF.md
# One-Time-Programmable Security Register

This block holds 128 bits of write-once storage for a memory device's command interface. The storage is split into two 64-bit halves. The factory half carries a unique device number that can never change. The user half starts erased (all ones). Software may program it and then freeze it for good. A separate lock word controls which half is frozen: bit 0 covers the factory half and bit 1 covers the user half.

Software drives the block with single-word write cycles. The low byte of a write selects a command. The program command needs two writes: the command byte first, then one write that carries an offset and a data word. Programming ANDs the new word into the stored one, so a bit can go from 1 to 0 but never back. A refused or misdirected program raises sticky status flags, and a separate command clears them.

Contents are readable only while the identifier mode is active. The stored values live in registers with no reset, and parameters set their power-up values, to stand in for non-volatile cells. Because the controller reset does not touch them, the stored values survive a reset.

Top module: `otp_prot_reg`

## Requirements
- R1: Reset clears both status flags and selects array mode, with `ident_active` = 0 and `rd_data` = 0. Stored contents keep their values through a reset.
- R2: A write whose low byte is 0x90 enters identifier mode. While in identifier mode, `rd_data` returns the stored word at `rd_addr`: offset 0 is the lock word, offsets 1 to 4 are the factory half, offsets 5 to 8 are the user half, and any other offset reads 0. A write whose low byte is 0xFF returns to array mode, where `rd_data` is 0.
- R3: Offset 1+k reads bits [16k+15:16k] of `FACTORY_ID`. A program to offsets 1 to 4 leaves the data unchanged and sets both `st_prog_err` and `st_locked`.
- R4: A write whose low byte is 0xC0, followed by a write to offset 5 to 8 while lock bit 1 is 1, replaces that user word with (old AND new). The status flags do not change.
- R5: A program can never turn a stored 0 bit into 1, whether in the user half or in the lock word.
- R6: Programming 0xFFFD to offset 0 clears lock bit 1. From then on, any program to the user half leaves the data unchanged and sets both status flags.
- R7: At power-up the lock word reads 0xFFFE, so the factory half is locked from the start.
- R8: A program to an offset above 8 changes nothing, sets `st_prog_err` and leaves `st_locked` clear.
- R9: The status flags stay set through later programs that succeed. A write whose low byte is 0x50, issued outside a program sequence, clears both flags.
- R10: A write whose low byte is not 0xC0, 0x90, 0xFF or 0x50, issued outside a program sequence, leaves the mode and the status unchanged.
- R11: The write that follows 0xC0 is always taken as program data and never decoded as a command. After it the block is in array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Word offset used by the program cycle |
| wr_data | input | WORD_W | Command byte in [7:0], or program data |
| rd_addr | input | ADDR_W | Word offset to read |
| rd_data | output | WORD_W | Stored word in identifier mode, otherwise 0 |
| ident_active | output | 1 | High while identifier mode is active |
| st_prog_err | output | 1 | Sticky flag: a program was refused |
| st_locked | output | 1 | Sticky flag: a program hit a locked half |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe and that `wr_addr` and `wr_data` hold steady across the clock edge that samples them. The bench drives every write for exactly one cycle, from the falling edge. The freeze and no-rise properties rely on the stored registers starting from their parameter values with no reset. The bench therefore keeps the default parameters and never forces storage, and it reaches every state it tests through command writes alone. A reset in the middle of the run shows that the contents survive while the controller state returns to its reset values.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        M_ARRAY = 2'd0,
        M_IDENT = 2'd1,
        M_SETUP = 2'd2
    } mode_e;

    localparam logic [7:0] OP_PROGRAM = 8'hC0;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_CLRSTAT = 8'h50;

    typedef struct packed {
        mode_e mode;
        logic  prog_err;
        logic  lock_err;
    } ctl_t;
endpackage

// File: rtl/otp_cmd_ctl.sv
module otp_cmd_ctl
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_cmd,
    input  logic       prog_fail,
    input  logic       prog_lockfail,
    output logic       prog_fire,
    output mode_e      mode,
    output logic       st_prog_err,
    output logic       st_locked
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        prog_fire = 1'b0;
        if (wr_en) begin
            if (ctl_q.mode == M_SETUP) begin
                prog_fire      = 1'b1;
                ctl_d.mode     = M_ARRAY;
                ctl_d.prog_err = ctl_q.prog_err | prog_fail;
                ctl_d.lock_err = ctl_q.lock_err | prog_lockfail;
            end else begin
                case (wr_cmd)
                    OP_PROGRAM: ctl_d.mode = M_SETUP;
                    OP_IDENT:   ctl_d.mode = M_IDENT;
                    OP_ARRAY:   ctl_d.mode = M_ARRAY;
                    OP_CLRSTAT: begin
                        ctl_d.prog_err = 1'b0;
                        ctl_d.lock_err = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: M_ARRAY, prog_err: 1'b0, lock_err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode        = ctl_q.mode;
    assign st_prog_err = ctl_q.prog_err;
    assign st_locked   = ctl_q.lock_err;
endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int                  WORD_W     = 16,
    parameter int                  SEG_BITS   = 64,
    parameter int                  ADDR_W     = 4,
    parameter logic [SEG_BITS-1:0] FACTORY_ID = 64'h1234_5678_9ABC_DEF0,
    parameter logic [SEG_BITS-1:0] USER_INIT  = '1,
    parameter logic [WORD_W-1:0]   LOCK_INIT  = 16'hFFFE
) (
    input  logic                clk,
    input  logic                prog_fire,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_word,
    output logic                prog_fail,
    output logic                prog_lockfail,
    output logic [SEG_BITS-1:0] fact_seg,
    output logic [SEG_BITS-1:0] user_seg,
    output logic [WORD_W-1:0]   lock_word
);
    localparam int SEG_WORDS = SEG_BITS / WORD_W;
    localparam int SIDX_W    = (SEG_WORDS > 1) ? $clog2(SEG_WORDS) : 1;
    localparam int FACT_BASE = 1;
    localparam int USER_BASE = 1 + SEG_WORDS;
    localparam int LAST_OFS  = 2 * SEG_WORDS;

    typedef struct packed {
        logic [WORD_W-1:0]   lock;
        logic [SEG_BITS-1:0] user;
        logic [SEG_BITS-1:0] fact;
    } store_t;

    // No reset: power-up values model non-volatile cells.
    store_t st_d;
    store_t st_q = '{lock: LOCK_INIT, user: USER_INIT, fact: FACTORY_ID};

    logic [WORD_W-1:0] fact_w [SEG_WORDS];
    logic [WORD_W-1:0] user_w [SEG_WORDS];

    for (genvar g = 0; g < SEG_WORDS; g++) begin : g_words
        assign fact_w[g] = st_q.fact[g*WORD_W +: WORD_W];
        assign user_w[g] = st_q.user[g*WORD_W +: WORD_W];
    end

    logic              w_lock, w_fact, w_user;
    logic [SIDX_W-1:0] w_sub;

    always_comb begin
        w_lock = (wr_addr == ADDR_W'(0));
        w_fact = (wr_addr >= ADDR_W'(FACT_BASE)) && (wr_addr < ADDR_W'(USER_BASE));
        w_user = (wr_addr >= ADDR_W'(USER_BASE)) && (wr_addr <= ADDR_W'(LAST_OFS));
        w_sub  = w_user ? SIDX_W'(wr_addr - ADDR_W'(USER_BASE)) : '0;

        prog_lockfail = w_fact | (w_user & ~st_q.lock[1]);
        prog_fail     = prog_lockfail | ~(w_lock | w_fact | w_user);

        st_d = st_q;
        if (prog_fire && !prog_fail) begin
            if (w_lock) begin
                st_d.lock = st_q.lock & wr_data;
            end
            if (w_user) begin
                st_d.user[int'(w_sub)*WORD_W +: WORD_W] = user_w[w_sub] & wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_word = '0;
        if (rd_addr == ADDR_W'(0)) begin
            rd_word = st_q.lock;
        end else if (rd_addr < ADDR_W'(USER_BASE)) begin
            rd_word = fact_w[SIDX_W'(rd_addr - ADDR_W'(FACT_BASE))];
        end else if (rd_addr <= ADDR_W'(LAST_OFS)) begin
            rd_word = user_w[SIDX_W'(rd_addr - ADDR_W'(USER_BASE))];
        end
    end

    assign fact_seg  = st_q.fact;
    assign user_seg  = st_q.user;
    assign lock_word = st_q.lock;
endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter int                  WORD_W     = 16,
    parameter int                  SEG_BITS   = 64,
    parameter int                  ADDR_W     = 4,
    parameter logic [SEG_BITS-1:0] FACTORY_ID = 64'h1234_5678_9ABC_DEF0,
    parameter logic [SEG_BITS-1:0] USER_INIT  = '1,
    parameter logic [WORD_W-1:0]   LOCK_INIT  = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              ident_active,
    output logic              st_prog_err,
    output logic              st_locked
);
    mode_e               mode;
    logic                prog_fire, prog_fail, prog_lockfail, in_setup;
    logic [WORD_W-1:0]   rd_word, lock_word;
    logic [SEG_BITS-1:0] fact_seg, user_seg;

    otp_cmd_ctl u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_cmd        (wr_data[7:0]),
        .prog_fail     (prog_fail),
        .prog_lockfail (prog_lockfail),
        .prog_fire     (prog_fire),
        .mode          (mode),
        .st_prog_err   (st_prog_err),
        .st_locked     (st_locked)
    );

    otp_store #(
        .WORD_W     (WORD_W),
        .SEG_BITS   (SEG_BITS),
        .ADDR_W     (ADDR_W),
        .FACTORY_ID (FACTORY_ID),
        .USER_INIT  (USER_INIT),
        .LOCK_INIT  (LOCK_INIT)
    ) u_store (
        .clk           (clk),
        .prog_fire     (prog_fire),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_word       (rd_word),
        .prog_fail     (prog_fail),
        .prog_lockfail (prog_lockfail),
        .fact_seg      (fact_seg),
        .user_seg      (user_seg),
        .lock_word     (lock_word)
    );

    assign ident_active = (mode == M_IDENT);
    assign in_setup     = (mode == M_SETUP);
    assign rd_data      = ident_active ? rd_word : '0;
endmodule

// File: rtl/otp_prot_reg_chk.sv
module otp_prot_reg_chk #(
    parameter int WORD_W   = 16,
    parameter int SEG_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wr_cmd,
    input logic                in_setup,
    input logic                ident_active,
    input logic [WORD_W-1:0]   rd_data,
    input logic                st_prog_err,
    input logic                st_locked,
    input logic [SEG_BITS-1:0] fact_seg,
    input logic [SEG_BITS-1:0] user_seg,
    input logic [WORD_W-1:0]   lock_word
);
    p_locked_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_locked |-> st_prog_err);

    p_factory_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(fact_seg));

    p_user_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (user_seg & ~$past(user_seg)) == '0);

    p_lock_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_word & ~$past(lock_word)) == '0);

    p_user_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_word[1] |=> $stable(user_seg));

    p_factory_lockbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_word[0]);

    p_clear_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_setup && wr_cmd == 8'h50) |=> (!st_prog_err && !st_locked));

    p_array_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ident_active |-> rd_data == '0);
endmodule

bind otp_prot_reg otp_prot_reg_chk #(
    .WORD_W   (WORD_W),
    .SEG_BITS (SEG_BITS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_cmd       (wr_data[7:0]),
    .in_setup     (in_setup),
    .ident_active (ident_active),
    .rd_data      (rd_data),
    .st_prog_err  (st_prog_err),
    .st_locked    (st_locked),
    .fact_seg     (fact_seg),
    .user_seg     (user_seg),
    .lock_word    (lock_word)
);

// File: tb/otp_prot_reg_tb_top.sv
module otp_prot_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] FID = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ident_active, st_prog_err, st_locked;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prot_reg dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .ident_active (ident_active),
        .st_prog_err  (st_prog_err),
        .st_locked    (st_locked)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(logic [3:0] a, logic [15:0] d);
        wr(4'd0, 16'h00C0);
        wr(a, d);
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic flags_chk(string tag, logic pe, logic lk);
        chk({tag, " prog_err"}, {15'd0, st_prog_err}, {15'd0, pe});
        chk({tag, " locked"}, {15'd0, st_locked}, {15'd0, lk});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ident after reset", {15'd0, ident_active}, 16'd0);
        flags_chk("R1", 1'b0, 1'b0);
        rd_chk("R1 rd in array mode", 4'd1, 16'h0000);
    endtask

    task automatic t_ident_map;
        wr(4'd0, 16'h0090);
        chk("R2 ident entered", {15'd0, ident_active}, 16'd1);
        rd_chk("R7 lock word power-up", 4'd0, 16'hFFFE);
        for (int k = 0; k < 4; k++) begin
            rd_chk("R3 factory word", 4'(1 + k), FID[16*k +: 16]);
            rd_chk("R2 user erased", 4'(5 + k), 16'hFFFF);
        end
        rd_chk("R2 out of range reads 0", 4'd9, 16'h0000);
        wr(4'd0, 16'h00FF);
        chk("R2 ident left", {15'd0, ident_active}, 16'd0);
        rd_chk("R2 array mode reads 0", 4'd0, 16'h0000);
    endtask

    task automatic t_unknown_cmd;
        wr(4'd0, 16'h0012);
        chk("R10 array stays", {15'd0, ident_active}, 16'd0);
        wr(4'd0, 16'h0090);
        wr(4'd0, 16'h0034);
        chk("R10 ident stays", {15'd0, ident_active}, 16'd1);
        flags_chk("R10", 1'b0, 1'b0);
        wr(4'd0, 16'h00FF);
    endtask

    task automatic t_user_program;
        prog(4'd5, 16'hF0F0);
        flags_chk("R4", 1'b0, 1'b0);
        wr(4'd0, 16'h0090);
        rd_chk("R4 first program", 4'd5, 16'hF0F0);
        prog(4'd5, 16'h0FFF);
        wr(4'd0, 16'h0090);
        rd_chk("R4 AND with old", 4'd5, 16'h00F0);
        prog(4'd5, 16'hFFFF);
        wr(4'd0, 16'h0090);
        rd_chk("R5 no 0 to 1", 4'd5, 16'h00F0);
        rd_chk("R4 neighbour untouched", 4'd6, 16'hFFFF);
    endtask

    task automatic t_data_not_cmd;
        wr(4'd0, 16'h00FF);
        prog(4'd6, 16'h0090);
        chk("R11 data not decoded", {15'd0, ident_active}, 16'd0);
        wr(4'd0, 16'h0090);
        rd_chk("R11 data stored", 4'd6, 16'h0090);
        prog(4'd8, 16'h00FF);
        chk("R11 back to array", {15'd0, ident_active}, 16'd0);
    endtask

    task automatic t_factory_refused;
        prog(4'd2, 16'h0000);
        flags_chk("R3 refused", 1'b1, 1'b1);
        wr(4'd0, 16'h0090);
        rd_chk("R3 factory unchanged", 4'd2, FID[31:16]);
        prog(4'd7, 16'h7FFF);
        flags_chk("R9 sticky", 1'b1, 1'b1);
        wr(4'd0, 16'h0050);
        flags_chk("R9 cleared", 1'b0, 1'b0);
    endtask

    task automatic t_out_of_range;
        prog(4'd12, 16'h0000);
        flags_chk("R8", 1'b1, 1'b0);
        wr(4'd0, 16'h0090);
        rd_chk("R8 lock untouched", 4'd0, 16'hFFFE);
        wr(4'd0, 16'h0050);
        flags_chk("R9 clear after R8", 1'b0, 1'b0);
    endtask

    task automatic t_lock_user;
        prog(4'd0, 16'hFFFD);
        flags_chk("R6 lock write ok", 1'b0, 1'b0);
        wr(4'd0, 16'h0090);
        rd_chk("R6 lock bit cleared", 4'd0, 16'hFFFC);
        prog(4'd7, 16'h0000);
        flags_chk("R6 refused", 1'b1, 1'b1);
        wr(4'd0, 16'h0090);
        rd_chk("R6 user unchanged", 4'd7, 16'h7FFF);
        wr(4'd0, 16'h0050);
        prog(4'd0, 16'hFFFF);
        wr(4'd0, 16'h0090);
        rd_chk("R5 lock cannot reopen", 4'd0, 16'hFFFC);
    endtask

    task automatic t_persist;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ident cleared", {15'd0, ident_active}, 16'd0);
        wr(4'd0, 16'h0090);
        rd_chk("R1 user persists", 4'd5, 16'h00F0);
        rd_chk("R1 lock persists", 4'd0, 16'hFFFC);
    endtask

    initial begin
        t_reset();
        t_ident_map();
        t_unknown_cmd();
        t_user_program();
        t_data_not_cmd();
        t_factory_refused();
        t_out_of_range();
        t_lock_user();
        t_persist();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule